// File: doc/BRIEF.md
# Double-to-Single Float Narrowing Converter

This block narrows a 64-bit double-precision register image into a 32-bit single-precision word by truncation. The caller presents the double on `din` together with a one-cycle `start` pulse. The block returns the single-precision word on `dout` together with a one-cycle `done` pulse. While a conversion is in flight, `busy` is high. There is no rounding, no overflow handling and no exception flag.

The biased double exponent (field `din[62:52]`) picks one of three paths:

- **Direct selection.** Exponents above 896, and the all-zero magnitude, need no shifting. The result is taken straight from input bits.
- **Denormalization.** Exponents from 874 up to 896 lie just below the single normal range. They go through a denormalizing loop that shifts a 53-bit working fraction right by one place per clock. The loop stops when the working exponent reaches -126.
- **Undefined.** Every other exponent gives an undefined result, which the block returns as zero.

Bit numbering throughout is little-endian: `din[63]` is the sign and `dout[31]` is the sign.

Top module: `dp_narrow`

## Requirements
- R1: After reset, `busy`, `done` and `dout` are all zero.
- R2: When the exponent field `din[62:52]` is greater than 896, `dout[31:30]` equals `din[63:62]` and `dout[29:0]` equals `din[58:29]`.
- R3: When `din[62:0]` is all zero, the same direct mapping applies, so `dout` is `{din[63], 31'b0}` and the sign is kept.
- R4: When the exponent field E satisfies 874 <= E <= 896, let F = `{1'b1, din[51:0]}` shifted right by 897-E places with zeros entering at the top. Then `dout` = `{din[63], 8'b0, F[51:29]}`, and the dropped low bits are not rounded.
- R5: When E is below 874 and `din[62:0]` is not all zero (this includes E = 0 with a nonzero fraction), `dout` is zero.
- R6: The loop performs one shift per clock. With N = 897-E on the denormalizing path and N = 0 otherwise, `done` is high for exactly one cycle, N+1 clock edges after the edge that samples `start`.
- R7: `busy` is high from the edge that samples `start` until the edge that raises `done`, where it falls.
- R8: A `start` sampled while `busy` is high is ignored. `dout` changes only on the edge that raises `done` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion of `din` (ignored while busy) |
| din | input | 64 | Double-precision input image |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse, `dout` valid |
| dout | output | 32 | Single-precision result |

## Verification
The bench drives doubles whose exponents sit on each side of the two window edges: 897 against 896, and 874 against 873. This separates the direct, one-shift, full-length-shift and undefined paths. Zero, negative zero, infinity and a NaN with a busy fraction confirm that the all-zero-magnitude and top-exponent cases use direct selection, and that the sign is preserved. An exponent of zero with a nonzero fraction shows that subnormal doubles fall into the zero result. A normal value and a mid-window value with scattered fraction bits show that the right bits are selected and truncated. A second start injected mid-loop, with different data, shows that a running conversion is not disturbed.

// File: rtl/dp_narrow.sv
module dp_narrow #(
  parameter int DW  = 64,
  parameter int SW  = 32,
  parameter int EW  = 11,
  parameter int FW  = 52,
  parameter int LO_EXP = 874,
  parameter int HI_EXP = 896
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] din,
  output logic          busy,
  output logic          done,
  output logic [SW-1:0] dout
);
  localparam int MAXSH = HI_EXP + 1 - LO_EXP;
  localparam int CW    = $clog2(MAXSH + 1);
  localparam int SFW   = SW - 9;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_FIN} state_t;

  state_t        state;
  logic [FW:0]   frac;
  logic [CW-1:0] cnt;
  logic          sgn;
  logic [SW-1:0] pend;

  logic [EW-1:0] exp_in;
  logic          mag_zero, go_direct, go_denorm;
  logic [EW-1:0] sh_amt;
  logic [FW:0]   frac_nx;

  assign exp_in    = din[DW-2 -: EW];
  assign mag_zero  = (din[DW-2:0] == '0);
  assign go_direct = (exp_in > EW'(HI_EXP)) || mag_zero;
  assign go_denorm = !go_direct && (exp_in >= EW'(LO_EXP));
  assign sh_amt    = EW'(HI_EXP + 1) - exp_in;
  assign frac_nx   = {1'b0, frac[FW:1]};
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      frac  <= '0;
      cnt   <= '0;
      sgn   <= 1'b0;
      pend  <= '0;
      done  <= 1'b0;
      dout  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          sgn <= din[DW-1];
          if (go_denorm) begin
            frac  <= {1'b1, din[FW-1:0]};
            cnt   <= sh_amt[CW-1:0];
            state <= S_SHIFT;
          end else begin
            pend  <= go_direct ? {din[DW-1 -: 2], din[DW-6 -: SW-2]} : '0;
            state <= S_FIN;
          end
        end
        S_SHIFT: begin
          frac <= frac_nx;
          cnt  <= cnt - 1'b1;
          if (cnt == CW'(1)) begin
            pend  <= {sgn, 8'b0, frac_nx[FW-1 -: SFW]};
            state <= S_FIN;
          end
        end
        S_FIN: begin
          dout  <= pend;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dp_narrow_chk.sv
module dp_narrow_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] dout
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);
  assert_busy_falls_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_dout_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dout));
  assert_reset_idle_R1: assert property (@(posedge clk)
    !$past(rst_n) |-> (!busy && !done));
endmodule

bind dp_narrow dp_narrow_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .dout(dout)
);

// File: tb/dp_narrow_bench.sv
module dp_narrow_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] din = '0;
  logic        busy, done;
  logic [31:0] dout;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dp_narrow u_dp_narrow (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .busy(busy), .done(done), .dout(dout)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int shifts(input logic [63:0] d);
    int e = int'(d[62:52]);
    if (e > 896 || d[62:0] == 0) return 0;
    if (e >= 874) return 897 - e;
    return 0;
  endfunction

  function automatic logic [31:0] model(input logic [63:0] d);
    int e = int'(d[62:52]);
    logic [52:0] f;
    if (e > 896 || d[62:0] == 0) return {d[63:62], d[58:29]};
    if (e >= 874) begin
      f = {1'b1, d[51:0]} >> (897 - e);
      return {d[63], 8'b0, f[51:29]};
    end
    return 32'h0;
  endfunction

  function automatic logic [63:0] mk(input bit s, input int e, input logic [51:0] f);
    return {s, e[10:0], f};
  endfunction

  task automatic run(input logic [63:0] d, input string req, input int inject);
    int cyc = 0;
    int n = shifts(d);
    logic [31:0] exp_out = model(d);
    logic [31:0] prev;
    @(negedge clk);
    prev = dout;
    din = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7 busy after start", busy, 1);
    while (cyc < 100) begin
      @(posedge clk);
      #1;
      start = 1'b0;
      cyc++;
      if (done) break;
      if (busy !== 1'b1) chk(0, "R7 busy held", busy, 1);
      if (dout !== prev) chk(0, "R8 dout changed early", dout, prev);
      if (cyc == inject) begin
        start = 1'b1;
        din = ~d;
      end
    end
    chk(done === 1'b1, {req, " R6 done seen"}, done, 1);
    chk(cyc == n + 1, {req, " R6 latency"}, cyc, n + 1);
    chk(busy === 1'b0, {req, " R7 busy falls with done"}, busy, 0);
    chk(dout === exp_out, req, dout, exp_out);
    @(posedge clk);
    #1;
    chk(done === 1'b0, {req, " R6 single pulse"}, done, 0);
    chk(dout === exp_out, {req, " R8 dout holds"}, dout, exp_out);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    chk(dout === 32'h0, "R1 dout", dout, 0);
  endtask

  task automatic t_direct;
    run(64'h3FF0000000000000, "R2 one", 0);
    run(mk(1, 1100, 52'hA5A5_1234_5678_9), "R2 neg normal", 0);
    run(mk(0, 897, 52'hF_0F0F_0F0F_0F0F), "R2 exp 897 edge", 0);
    run(mk(0, 2047, 52'h0), "R2 infinity", 0);
    run(mk(1, 2047, 52'h8_0000_0000_1234), "R2 nan", 0);
  endtask

  task automatic t_zero;
    run(64'h0, "R3 pos zero", 0);
    run(64'h8000000000000000, "R3 neg zero", 0);
  endtask

  task automatic t_denorm;
    run(mk(0, 896, 52'hF_FFFF_FFFF_FFFF), "R4 exp 896 one shift", 0);
    run(mk(1, 885, 52'h5_A5A5_A5A5_A5A5), "R4 mid window", 0);
    run(mk(0, 874, 52'hF_FFFF_FFFF_FFFF), "R4 exp 874 full shift", 0);
  endtask

  task automatic t_undef;
    run(mk(0, 873, 52'hF_FFFF_FFFF_FFFF), "R5 exp 873", 0);
    run(mk(1, 0, 52'h0_0000_0000_0001), "R5 double subnormal", 0);
    run(mk(0, 100, 52'h1_2345_6789_ABCD), "R5 tiny", 0);
  endtask

  task automatic t_ignore;
    run(mk(1, 880, 52'h3_3333_3333_3333), "R8 start while busy ignored", 3);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_direct;
    t_zero;
    t_denorm;
    t_undef;
    t_ignore;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule